// File: doc/BRIEF.md
# Write-Protected Seconds Counter with Alarm

This block is a register-mapped real-time clock. It keeps a 32-bit seconds count, which advances once for each one-second pulse on `tick_i`. It compares each new count against a 32-bit alarm register. When they match it raises an alarm flag, which can drive an interrupt and a wakeup request. A separate one-second flag records every counting pulse and can drive its own interrupt.

Every state-changing write is guarded in two ways.

- **Unlock pattern.** Software first writes a 16-bit unlock pattern. That unlock is then used up by exactly one protected write.
- **Write ready.** After any accepted write, a write-ready bit stays low for a programmable number of bus cycles. This models the crossing into a slow clock domain. Software polls the bit before every write, and a write issued while it is low is dropped.

Reads are never blocked. `rdata_o` follows `addr_i` combinationally.

Top module: `locked_rtc`

Register offsets: control 0x00, seconds 0x04, alarm 0x08, trim 0x0C, wakeup enable 0x2C, wakeup status 0x30, unlock 0x3C. Any other offset reads 0 and ignores writes.

## Requirements
- R1: After reset, the registers behave as follows.
  - Control (0x00) reads 0x80, with bit 7 being write ready.
  - Seconds, alarm, trim, wakeup enable, wakeup status and unlock all read 0, so the block is locked.
  - `alarm_irq_o`, `tick_irq_o` and `wake_o` are 0.
- R2: An accepted write makes control bit 7 read 0 for exactly BUSY_CYC cycles (default 4), starting at the clock edge that takes the write; after that it reads 1 again.
- R3: An accepted write to 0x3C unlocks the block when `wdata_i[15:0]` is 0xA55A and locks it for any other value. Bit 31 of 0x3C reads 1 exactly while the block is unlocked.
- R4: Any write, including an unlock write, issued while write ready is 0 is ignored.
- R5: A write to 0x00, 0x04, 0x08, 0x0C, 0x2C or 0x30 while the block is locked is ignored. One such write while unlocked takes effect and locks the block again.
- R6: On a `tick_i` pulse with control bit 0 (enable) set, seconds increments and wraps from 0xFFFFFFFF to 0. With bit 0 clear, seconds holds.
- R7: The alarm flag (control bit 4) is set by a counting pulse when control bit 2 (alarm enable) is 1 and the incremented seconds equals the alarm register. It is not set when bit 2 is 0.
- R8: Every counting pulse sets the one-second flag (control bit 6). `tick_irq_o` equals bit 6 AND bit 5.
- R9: For control bits 4 and 6, a written 0 clears the flag and a written 1 leaves it unchanged. Bits 0, 2, 3 and 5 take the written value.
- R10: `alarm_irq_o` equals control bit 4 AND bit 3. `wake_o` equals control bit 4 AND bit 0 of 0x2C.
- R11: Bit 0 of 0x30 becomes 1 one cycle after `wake_o` is 1 and stays set until a protected write with bit 0 = 0 clears it.
- R12: The trim register at 0x0C keeps bits 25:16 and 15:0 of the written value; all other bits read 0.
- R13: If a seconds write and a counting pulse fall in the same cycle, seconds takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second pulse, one cycle wide |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| alarm_irq_o | output | 1 | Alarm interrupt |
| tick_irq_o | output | 1 | One-second interrupt |
| wake_o | output | 1 | Wakeup request from the alarm |

## Verification
The bench measures the write-ready low window cycle by cycle. A counter that is off by one, or that never reloads, shows up as a wrong count.

It also drives the following corner cases:
- writes issued during the busy window, both protected writes and unlock writes;
- a second protected write after a single unlock, which a design with a sticky unlock would accept;
- seconds stepping across the 32-bit wrap;
- alarm targets placed 1 to 5 pulses ahead, which would expose a compare against the old count instead of the new one;
- a seconds write colliding with a pulse, where a wrong priority loses the written value;
- flag writes of 1, which a design that treats the flag bit as plain storage would fail on.

// File: rtl/locked_rtc_pkg.sv
package locked_rtc_pkg;
  localparam logic [31:0] UNLOCK_PAT = 32'h0000_A55A;
  localparam logic [31:0] TRIM_MASK  = 32'h03FF_FFFF;

  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_SECS  = 'h04;
  localparam int unsigned OFS_ALRM  = 'h08;
  localparam int unsigned OFS_TRIM  = 'h0C;
  localparam int unsigned OFS_WEN   = 'h2C;
  localparam int unsigned OFS_WSTAT = 'h30;
  localparam int unsigned OFS_UNLK  = 'h3C;

  // control bit positions, decoded by software
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_AE    = 2;
  localparam int unsigned B_AIE   = 3;
  localparam int unsigned B_AFLG  = 4;
  localparam int unsigned B_TIE   = 5;
  localparam int unsigned B_TFLG  = 6;
  localparam int unsigned B_RDY   = 7;

  typedef struct packed {
    logic tflg;
    logic tie;
    logic aflg;
    logic aie;
    logic ae;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/locked_rtc_gate.sv
module locked_rtc_gate #(
  parameter int unsigned BUSY_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic unlock_sel_i,
  input  logic pattern_ok_i,
  input  logic prot_sel_i,
  output logic rdy_o,
  output logic unlocked_o,
  output logic commit_o
);
  localparam int unsigned CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] busy_q;
  logic          unl_q;
  logic          accept;
  logic          unlock_wr;

  assign rdy_o      = (busy_q == '0);
  assign unlocked_o = unl_q;
  assign unlock_wr  = wr_i && rdy_o && unlock_sel_i;
  assign commit_o   = wr_i && rdy_o && prot_sel_i && unl_q;
  assign accept     = unlock_wr || commit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
    end else if (accept) begin
      busy_q <= CW'(BUSY_CYC);
    end else if (busy_q != '0) begin
      busy_q <= busy_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        unl_q <= 1'b0;
    else if (unlock_wr) unl_q <= pattern_ok_i;
    else if (commit_o)  unl_q <= 1'b0;
  end

  a_r2_busy_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !rdy_o);
  a_r4_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rdy_o) |=> (unlocked_o == $past(unlocked_o)));
  a_r5_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !unlocked_o);
endmodule

// File: rtl/locked_rtc_count.sv
module locked_rtc_count
  import locked_rtc_pkg::*;
#(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_ctrl_i,
  input  logic             wr_secs_i,
  input  logic             wr_alrm_i,
  input  logic [31:0]      wdata_i,
  output logic [SEC_W-1:0] secs_o,
  output logic [SEC_W-1:0] alrm_o,
  output ctrl_t            ctrl_o
);
  logic [SEC_W-1:0] secs_q, alrm_q, secs_nxt;
  ctrl_t            ctrl_q;
  logic             step, count;

  assign step     = ctrl_q.en && tick_i;
  assign count    = step && !wr_secs_i;
  assign secs_nxt = secs_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        secs_q <= '0;
    else if (wr_secs_i) secs_q <= wdata_i[SEC_W-1:0];
    else if (step)      secs_q <= secs_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        alrm_q <= '0;
    else if (wr_alrm_i) alrm_q <= wdata_i[SEC_W-1:0];
  end

  // flag set by a counting pulse wins over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl_i) begin
        ctrl_q.en   <= wdata_i[B_EN];
        ctrl_q.ae   <= wdata_i[B_AE];
        ctrl_q.aie  <= wdata_i[B_AIE];
        ctrl_q.tie  <= wdata_i[B_TIE];
        ctrl_q.aflg <= ctrl_q.aflg & wdata_i[B_AFLG];
        ctrl_q.tflg <= ctrl_q.tflg & wdata_i[B_TFLG];
      end
      if (count) ctrl_q.tflg <= 1'b1;
      if (count && ctrl_q.ae && (secs_nxt == alrm_q)) ctrl_q.aflg <= 1'b1;
    end
  end

  assign secs_o = secs_q;
  assign alrm_o = alrm_q;
  assign ctrl_o = ctrl_q;

  a_r6_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.en && !wr_secs_i) |=> (secs_o == $past(secs_o)));
  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && tick_i && !wr_secs_i && (secs_q == '1)) |=> (secs_o == '0));
  a_r7_alarm_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.en && tick_i && !wr_secs_i && ctrl_q.ae && (secs_q + 1'b1 == alrm_q))
      |=> ctrl_o.aflg);
  a_r13_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_secs_i |=> (secs_o == $past(wdata_i[SEC_W-1:0])));
endmodule

// File: rtl/locked_rtc.sv
module locked_rtc
  import locked_rtc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BUSY_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              alarm_irq_o,
  output logic              tick_irq_o,
  output logic              wake_o
);
  localparam int unsigned SEC_W = 32;

  logic sel_ctrl, sel_secs, sel_alrm, sel_trim, sel_wen, sel_wstat, sel_unlk;
  logic prot_sel, wr, rdy, unlocked, commit;
  logic [SEC_W-1:0] secs, alrm;
  ctrl_t ctrl;
  logic [31:0] trim_q;
  logic wen_q, wstat_q;

  assign sel_ctrl  = (addr_i == ADDR_W'(OFS_CTRL));
  assign sel_secs  = (addr_i == ADDR_W'(OFS_SECS));
  assign sel_alrm  = (addr_i == ADDR_W'(OFS_ALRM));
  assign sel_trim  = (addr_i == ADDR_W'(OFS_TRIM));
  assign sel_wen   = (addr_i == ADDR_W'(OFS_WEN));
  assign sel_wstat = (addr_i == ADDR_W'(OFS_WSTAT));
  assign sel_unlk  = (addr_i == ADDR_W'(OFS_UNLK));
  assign prot_sel  = sel_ctrl | sel_secs | sel_alrm | sel_trim | sel_wen | sel_wstat;
  assign wr        = req_i && we_i;

  locked_rtc_gate #(.BUSY_CYC(BUSY_CYC)) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr),
    .unlock_sel_i (sel_unlk),
    .pattern_ok_i (wdata_i[15:0] == UNLOCK_PAT[15:0]),
    .prot_sel_i   (prot_sel),
    .rdy_o        (rdy),
    .unlocked_o   (unlocked),
    .commit_o     (commit)
  );

  locked_rtc_count #(.SEC_W(SEC_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_ctrl_i (commit && sel_ctrl),
    .wr_secs_i (commit && sel_secs),
    .wr_alrm_i (commit && sel_alrm),
    .wdata_i   (wdata_i),
    .secs_o    (secs),
    .alrm_o    (alrm),
    .ctrl_o    (ctrl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_q  <= '0;
      wen_q   <= 1'b0;
      wstat_q <= 1'b0;
    end else begin
      if (commit && sel_trim) trim_q <= wdata_i & TRIM_MASK;
      if (commit && sel_wen)  wen_q  <= wdata_i[0];
      if (commit && sel_wstat) wstat_q <= wdata_i[0];
      if (wake_o) wstat_q <= 1'b1;
    end
  end

  assign alarm_irq_o = ctrl.aflg && ctrl.aie;
  assign tick_irq_o  = ctrl.tflg && ctrl.tie;
  assign wake_o      = ctrl.aflg && wen_q;

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      sel_ctrl: begin
        rdata_o[B_RDY]  = rdy;
        rdata_o[B_TFLG] = ctrl.tflg;
        rdata_o[B_TIE]  = ctrl.tie;
        rdata_o[B_AFLG] = ctrl.aflg;
        rdata_o[B_AIE]  = ctrl.aie;
        rdata_o[B_AE]   = ctrl.ae;
        rdata_o[B_EN]   = ctrl.en;
      end
      sel_secs:  rdata_o = secs;
      sel_alrm:  rdata_o = alrm;
      sel_trim:  rdata_o = trim_q;
      sel_wen:   rdata_o[0] = wen_q;
      sel_wstat: rdata_o[0] = wstat_q;
      sel_unlk:  rdata_o[31] = unlocked;
      default:   rdata_o = '0;
    endcase
  end

  a_r11_wake_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> (wstat_q == 1'b1));
  a_r5_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && !tick_i) |=> $stable(secs));
endmodule

// File: tb/locked_rtc_test.sv
`timescale 1ns/1ps
module locked_rtc_test;
  localparam int unsigned BUSY = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        alarm_irq_o, tick_irq_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  locked_rtc #(.ADDR_W(8), .BUSY_CYC(BUSY)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .alarm_irq_o(alarm_irq_o), .tick_irq_o(tick_irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic wait_rdy();
    logic [31:0] d;
    rd(8'h00, d);
    while (!d[7]) begin
      @(negedge clk);
      rd(8'h00, d);
    end
  endtask

  task automatic pwr(input logic [7:0] a, input logic [31:0] d);
    wait_rdy();
    wr(8'h3C, 32'h0000_A55A);
    wait_rdy();
    wr(a, d);
    wait_rdy();
  endtask

  task automatic tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, exp;
    int cnt;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, d); chk("R1 ctrl", d, 32'h80);
    rd(8'h04, d); chk("R1 secs", d, 0);
    rd(8'h08, d); chk("R1 alarm", d, 0);
    rd(8'h0C, d); chk("R1 trim", d, 0);
    rd(8'h3C, d); chk("R1 unlock", d, 0);
    rd(8'h30, d); chk("R1 wstat", d, 0);
    chk("R1 outputs", {29'd0, alarm_irq_o, tick_irq_o, wake_o}, 0);

    // R5 locked write ignored
    wr(8'h04, 32'h1234);
    rd(8'h04, d); chk("R5 locked secs", d, 0);

    // R3 unlock, R2 busy window length
    wait_rdy();
    wr(8'h3C, 32'hFFFF_A55A);
    cnt = 0;
    rd(8'h00, d);
    while (!d[7] && cnt < 100) begin
      cnt++;
      @(negedge clk);
      rd(8'h00, d);
    end
    chk("R2 busy cycles", cnt, BUSY);
    rd(8'h3C, d); chk("R3 unlocked", d, 32'h8000_0000);
    wr(8'h3C, 32'h0000_1234);
    wait_rdy();
    rd(8'h3C, d); chk("R3 wrong pattern locks", d, 0);

    // R4 writes during busy ignored
    wr(8'h3C, 32'h0000_A55A);
    wr(8'h04, 32'h55);
    wait_rdy();
    rd(8'h04, d); chk("R4 busy secs write", d, 0);
    rd(8'h3C, d); chk("R4 unlock kept", d, 32'h8000_0000);
    wr(8'h04, 32'h77);
    rd(8'h04, d); chk("R5 unlocked write", d, 32'h77);
    wr(8'h3C, 32'h0000_A55A);
    wait_rdy();
    rd(8'h3C, d); chk("R4 busy unlock ignored", d, 0);
    wr(8'h04, 32'h99);
    wait_rdy();
    rd(8'h04, d); chk("R5 one shot", d, 32'h77);

    // R6 counting across wrap
    pwr(8'h04, 32'hFFFF_FFF0);
    tick();
    rd(8'h04, d); chk("R6 disabled holds", d, 32'hFFFF_FFF0);
    pwr(8'h00, 32'h01);
    exp = 32'hFFFF_FFF0;
    for (int i = 0; i < 24; i++) begin
      tick();
      exp = exp + 1;
      rd(8'h04, d); chk("R6 count", d, exp);
    end

    // R8 one-second flag and interrupt, R9 write-1 keeps flag
    rd(8'h00, d); chk("R8 tick flag", d & 32'h40, 32'h40);
    chk("R8 irq off", tick_irq_o, 0);
    pwr(8'h00, 32'h61);
    chk("R9 write1 keeps, R8 irq on", tick_irq_o, 1);
    pwr(8'h00, 32'h21);
    chk("R9 write0 clears", tick_irq_o, 0);

    // R7 alarm sweep over distances 1..5
    for (int k = 1; k <= 5; k++) begin
      pwr(8'h04, 32'd1000 * k);
      pwr(8'h08, 32'd1000 * k + k);
      pwr(8'h00, 32'h05);
      for (int i = 1; i <= k + 1; i++) begin
        tick();
        rd(8'h00, d);
        chk("R7 alarm flag", d[4], (i >= k));
      end
    end

    // R7 alarm enable off blocks the flag
    pwr(8'h04, 32'd50);
    pwr(8'h08, 32'd51);
    pwr(8'h00, 32'h01);
    tick();
    rd(8'h00, d); chk("R7 disabled alarm", d[4], 0);

    // R10 interrupt and wakeup, R11 sticky status
    pwr(8'h04, 32'd60);
    pwr(8'h08, 32'd61);
    pwr(8'h00, 32'h05);
    tick();
    chk("R10 irq masked", alarm_irq_o, 0);
    pwr(8'h00, 32'h1D);
    chk("R10 irq on", alarm_irq_o, 1);
    chk("R10 wake off", wake_o, 0);
    pwr(8'h2C, 32'h1);
    chk("R10 wake on", wake_o, 1);
    rd(8'h30, d); chk("R11 status set", d, 1);
    pwr(8'h00, 32'h0D);
    chk("R10 wake clears", wake_o, 0);
    rd(8'h30, d); chk("R11 status sticky", d, 1);
    pwr(8'h30, 32'h0);
    rd(8'h30, d); chk("R11 status cleared", d, 0);

    // R12 trim masking
    pwr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R12 trim", d, 32'h03FF_FFFF);

    // R13 seconds write collides with a pulse
    pwr(8'h00, 32'h01);
    wr(8'h3C, 32'h0000_A55A);
    wait_rdy();
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = 8'h04; wdata_i = 32'h500; tick_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; tick_i = 1'b0;
    rd(8'h04, d); chk("R13 write wins", d, 32'h500);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule